// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to sixteen interrupt request lines and presents one interrupt to the processor. Each line has its own trigger mode and a 3-bit priority level. The trigger mode can be active-low, active-high, falling-edge or rising-edge. Level modes follow the synchronized line. Edge modes capture the selected transition in a sticky latch, which software clears by writing the source number.

Among the sources that are pending and have a non-zero level, the arbiter picks the highest level. A tie goes to the lower source number. The winner is forwarded only when its level is strictly greater than a single programmable threshold and the global enable is on. The result is registered. It is reported through a current-status word whose "nothing pending" flag is active-high, and it drives `irq_out`.

Software reaches the block through a 32-bit register bus with a valid/ready request side. `bus_ready` is held high, so a request is accepted in every cycle that `bus_valid` is high. A read returns `rsp_valid` with data exactly one cycle after it is accepted. The response side has no back-pressure, so the requester must take the data in that cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the following all read 0: the enable register, both mode registers, all level registers and the threshold register. `irq_out` is low and the current-status word (0xA0) reads 0x0001_0000.
- R2: Register map, word-aligned only.
  - Enable is bit 0 of 0x00.
  - Source n's 2-bit mode sits at 0x04 + 4*(n/8), bits (n mod 8)*2 +: 2.
  - Source n's 3-bit level sits at 0x10 + 4*((n mod 16)/2), bit (n odd ? 8 : 0) +: 3. The other bits of each 8-bit slot read 0.
  - The threshold is bits 2:0 of 0x40.
  - Every other offset, and every unaligned address, ignores writes and reads 0.
- R3: Mode 00 makes a source pending while its synchronized line is 0, and mode 01 while it is 1. Register 0x80 returns the pending vector, with bit n for source n.
- R4: Mode 11 latches a 0-to-1 transition of the synchronized line and mode 10 latches a 1-to-0 transition. The latch stays set after the line returns.
- R5: Writing 0x60 with bit 8 set clears the edge latch of the source numbered in bits 4:0. A write with bit 8 clear changes nothing. A new edge in the same cycle as a clear wins.
- R6: A source whose level is 0 never causes an interrupt, even while it is pending.
- R7: The winner is the pending source with the highest non-zero level. Among equal levels the lowest source number wins.
- R8: The winner is forwarded only when its level is strictly greater than the threshold.
- R9: While enable bit 0 is clear, `irq_out` stays low.
- R10: `irq_out` is high exactly when bit 16 of the current-status word reads 0. In that case bits 10:8 hold the winning level and bits 4:0 hold the winning source. Otherwise the word reads 0x0001_0000.
- R11: `bus_ready` is always high. Every accepted read gives `rsp_valid` in the next cycle, and a write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_in | input | NUM_SRC | Asynchronous request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
Assertions check several properties on every cycle:
- an edge latch holds until its own clear, and a clear without a new edge empties it;
- no pending source outranks the arbiter's choice, and a tie never goes to a higher number;
- a cleared enable keeps the output low in the following cycle;
- every accepted read is answered in the next cycle, and no write is answered.

Only the directed scenarios can show the rest:
- the register-map layout;
- the polarity of each trigger mode;
- the strict comparison against the threshold;
- the exact fields of the current-status word;
- that level 0 masks a pending line.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int LVL_W     = 3;
  localparam int MODE_W    = 2;
  localparam int SRC_IDX_W = 5;
  localparam int MAX_SRC   = 16;
  localparam int MODE_REGS = 2;
  localparam int LVL_REGS  = 8;

  localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE0    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LVL_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CLR      = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CUR      = 8'hA0;

  localparam int CLR_STROBE_BIT = 8;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_mode_e;

  function automatic logic [ADDR_W-1:0] mode_addr(input int n);
    return OFS_MODE0 + ADDR_W'(4 * (n / 8));
  endfunction

  function automatic int mode_bit(input int n);
    return (n % 8) * MODE_W;
  endfunction

  function automatic logic [ADDR_W-1:0] lvl_addr(input int n);
    return OFS_LVL_BASE + ADDR_W'(4 * ((n % 16) / 2));
  endfunction

  function automatic int lvl_bit(input int n);
    return (n / 16) * 16 + (n % 2) * 8;
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_valid,
  input  logic                              bus_ready,
  input  logic                              bus_write,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic                              rsp_valid,
  output logic [DATA_W-1:0]                 rsp_rdata,
  input  logic [NUM_SRC-1:0]                pend_vec,
  input  logic [DATA_W-1:0]                 cur_word,
  output logic                              ctl_en,
  output logic [NUM_SRC-1:0][MODE_W-1:0]    mode_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0]     lvl_q,
  output logic [LVL_W-1:0]                  mask_lvl,
  output logic                              clr_valid,
  output logic [SRC_IDX_W-1:0]              clr_idx
);
  logic wr_acc, rd_acc;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] mode_word [MODE_REGS];
  logic [DATA_W-1:0] lvl_word  [LVL_REGS];

  assign wr_acc = bus_valid && bus_ready && bus_write;
  assign rd_acc = bus_valid && bus_ready && !bus_write;

  assign clr_valid = wr_acc && (bus_addr == OFS_CLR) && bus_wdata[CLR_STROBE_BIT];
  assign clr_idx   = bus_wdata[SRC_IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      mask_lvl <= '0;
      mode_q   <= '0;
      lvl_q    <= '0;
    end else if (wr_acc) begin
      if (bus_addr == OFS_ENABLE) ctl_en <= bus_wdata[0];
      if (bus_addr == OFS_MASK) mask_lvl <= bus_wdata[LVL_W-1:0];
      for (int n = 0; n < NUM_SRC; n++) begin
        if (bus_addr == mode_addr(n)) mode_q[n] <= bus_wdata[mode_bit(n) +: MODE_W];
        if (bus_addr == lvl_addr(n))  lvl_q[n]  <= bus_wdata[lvl_bit(n) +: LVL_W];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < MODE_REGS; k++) mode_word[k] = '0;
    for (int k = 0; k < LVL_REGS; k++)  lvl_word[k]  = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      mode_word[n / 8][mode_bit(n) +: MODE_W]     = mode_q[n];
      lvl_word[(n % 16) / 2][lvl_bit(n) +: LVL_W] = lvl_q[n];
    end
  end

  always_comb begin
    rd_data = '0;
    if (bus_addr == OFS_ENABLE) rd_data = {{(DATA_W-1){1'b0}}, ctl_en};
    if (bus_addr == OFS_MASK)   rd_data = {{(DATA_W-LVL_W){1'b0}}, mask_lvl};
    if (bus_addr == OFS_PEND)   rd_data = {{(DATA_W-NUM_SRC){1'b0}}, pend_vec};
    if (bus_addr == OFS_CUR)    rd_data = cur_word;
    for (int k = 0; k < MODE_REGS; k++)
      if (bus_addr == OFS_MODE0 + ADDR_W'(4 * k)) rd_data = mode_word[k];
    for (int k = 0; k < LVL_REGS; k++)
      if (bus_addr == OFS_LVL_BASE + ADDR_W'(4 * k)) rd_data = lvl_word[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_rdata <= rd_acc ? rd_data : '0;
    end
  end

  // R11
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> rsp_valid);
  // R11
  wr_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_write) |=> !rsp_valid);
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             irq_in,
  input  logic [NUM_SRC-1:0][MODE_W-1:0] mode_q,
  input  logic                           clr_valid,
  input  logic [SRC_IDX_W-1:0]           clr_idx,
  output logic [NUM_SRC-1:0]             pend_vec
);
  localparam int SMSB = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] sh_q;
    logic prev_q, lat_q, s_now, rise, fall, is_edge, hit, clr_me;

    assign s_now   = sh_q[SMSB];
    assign rise    = s_now && !prev_q;
    assign fall    = !s_now && prev_q;
    assign is_edge = mode_q[g][1];
    assign hit     = (trig_mode_e'(mode_q[g]) == TRIG_RISE) ? rise : fall;
    assign clr_me  = clr_valid && (clr_idx == SRC_IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        sh_q   <= {sh_q[SYNC_STAGES-2:0], irq_in[g]};
        prev_q <= s_now;
        if (is_edge && hit) lat_q <= 1'b1;
        else if (clr_me)    lat_q <= 1'b0;
      end
    end

    always_comb begin
      case (trig_mode_e'(mode_q[g]))
        TRIG_LOW:  pend_vec[g] = !s_now;
        TRIG_HIGH: pend_vec[g] = s_now;
        default:   pend_vec[g] = lat_q;
      endcase
    end

    // R4
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && !clr_me) |=> lat_q);
    // R5
    lat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_me && !(is_edge && hit)) |=> !lat_q);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            pend_vec,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q,
  output logic                          win_valid,
  output logic [LVL_W-1:0]              win_lvl,
  output logic [SRC_IDX_W-1:0]          win_idx
);
  logic [NUM_SRC-1:0] cand;

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) cand[n] = pend_vec[n] && (lvl_q[n] != '0);
  end

  always_comb begin
    win_valid = 1'b0;
    win_lvl   = '0;
    win_idx   = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (cand[n] && (lvl_q[n] > win_lvl)) begin
        win_valid = 1'b1;
        win_lvl   = lvl_q[n];
        win_idx   = SRC_IDX_W'(n);
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    // R7
    arb_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> !(cand[g] && (lvl_q[g] > win_lvl)));
    // R7
    arb_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && cand[g] && (lvl_q[g] == win_lvl)) |-> (win_idx <= SRC_IDX_W'(g)));
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [NUM_SRC-1:0]   irq_in,
  output logic                 irq_out
);
  logic                          ctl_en, clr_valid, win_valid, fire;
  logic [NUM_SRC-1:0][MODE_W-1:0] mode_q;
  logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_q;
  logic [LVL_W-1:0]              mask_lvl, win_lvl, cur_lvl;
  logic [SRC_IDX_W-1:0]          clr_idx, win_idx, cur_src;
  logic [NUM_SRC-1:0]            pend_vec;
  logic                          cur_irq;
  logic [DATA_W-1:0]             cur_word;

  assign bus_ready = 1'b1;

  irq_regfile #(.NUM_SRC(NUM_SRC)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pend_vec(pend_vec), .cur_word(cur_word),
    .ctl_en(ctl_en), .mode_q(mode_q), .lvl_q(lvl_q), .mask_lvl(mask_lvl),
    .clr_valid(clr_valid), .clr_idx(clr_idx)
  );

  irq_src_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) det_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode_q(mode_q),
    .clr_valid(clr_valid), .clr_idx(clr_idx), .pend_vec(pend_vec)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .lvl_q(lvl_q),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  assign fire = ctl_en && win_valid && (win_lvl > mask_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_irq <= 1'b0;
      cur_lvl <= '0;
      cur_src <= '0;
    end else begin
      cur_irq <= fire;
      cur_lvl <= fire ? win_lvl : '0;
      cur_src <= fire ? win_idx : '0;
    end
  end

  assign irq_out  = cur_irq;
  assign cur_word = {15'b0, !cur_irq, 5'b0, cur_lvl, 3'b0, cur_src};

  // R9
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !irq_out);
  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && (win_lvl <= mask_lvl)) |=> !irq_out);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NSRC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rsp_valid, irq_out;
  logic [31:0] rsp_rdata;
  logic [NSRC-1:0] irq_in = '1;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R11 read response valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic expect_irq(input string tag, input logic [31:0] cur);
    settle();
    chk({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, ~cur[16]});
    expect_reg({tag, " R10 current status"}, 8'hA0, cur);
  endtask

  task automatic t_reset();
    chk("R1 irq_out low", {31'b0, irq_out}, 32'd0);
    chk("R11 bus_ready high", {31'b0, bus_ready}, 32'd1);
    expect_reg("R1 enable", 8'h00, 32'h0);
    expect_reg("R1 mode0", 8'h04, 32'h0);
    expect_reg("R1 mode1", 8'h08, 32'h0);
    for (int k = 0; k < 8; k++) expect_reg("R1 level", 8'h10 + 8'(4 * k), 32'h0);
    expect_reg("R1 mask", 8'h40, 32'h0);
    expect_reg("R1 current status", 8'hA0, 32'h0001_0000);
  endtask

  task automatic t_regmap();
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R11 no response to write", {31'b0, rsp_valid}, 32'd0);
    expect_reg("R2 mode0 readback", 8'h04, 32'h0000_FFFF);
    wr(8'h08, 32'h0000_1234);
    expect_reg("R2 mode1 readback", 8'h08, 32'h0000_1234);
    wr(8'h14, 32'hFFFF_FFFF);
    expect_reg("R2 level slot layout", 8'h14, 32'h0000_0707);
    wr(8'h40, 32'h0000_00FF);
    expect_reg("R2 mask width", 8'h40, 32'h0000_0007);
    wr(8'h00, 32'h0000_FFFF);
    expect_reg("R2 enable bit", 8'h00, 32'h0000_0001);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h05, 32'h0);
    expect_reg("R2 unused offset reads 0", 8'h0C, 32'h0);
    expect_reg("R2 unaligned reads 0", 8'h05, 32'h0);
    expect_reg("R2 clear reg reads 0", 8'h60, 32'h0);
    expect_reg("R2 mode0 untouched by stray writes", 8'h04, 32'h0000_FFFF);
    wr(8'h04, 0); wr(8'h08, 0); wr(8'h14, 0); wr(8'h40, 0); wr(8'h00, 0);
    expect_reg("R2 mode1 cleared", 8'h08, 32'h0);
  endtask

  task automatic t_level_modes();
    wr(8'h00, 32'h1);
    wr(8'h14, 32'h0000_0500);
    wr(8'h04, 32'h0000_0040);
    expect_irq("R3 high-active src3 pending", 32'h0000_0503);
    expect_reg("R3 pending vector", 8'h80, 32'h0000_0008);
    irq_in[3] = 1'b0;
    expect_irq("R3 high-active src3 released", 32'h0001_0000);
    wr(8'h04, 32'h0);
    expect_irq("R3 low-active src3 pending", 32'h0000_0503);
    irq_in[3] = 1'b1;
    expect_irq("R3 low-active src3 released", 32'h0001_0000);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_edge();
    wr(8'h20, 32'h0000_0600);
    wr(8'h08, 32'h0000_000C);
    irq_in[9] = 1'b0;
    expect_irq("R4 falling ignored in rising mode", 32'h0001_0000);
    irq_in[9] = 1'b1;
    expect_irq("R4 rising edge latched", 32'h0000_0609);
    irq_in[9] = 1'b0;
    expect_irq("R4 latch held after release", 32'h0000_0609);
    expect_reg("R4 pending vector", 8'h80, 32'h0000_0200);
  endtask

  task automatic t_clear();
    wr(8'h60, 32'h0000_0009);
    expect_irq("R5 clear without strobe ignored", 32'h0000_0609);
    wr(8'h60, 32'h0000_0108);
    expect_irq("R5 clear of other source ignored", 32'h0000_0609);
    wr(8'h60, 32'h0000_0109);
    expect_irq("R5 clear with strobe", 32'h0001_0000);
    wr(8'h08, 32'h0000_0008);
    irq_in[9] = 1'b1;
    expect_irq("R4 rising ignored in falling mode", 32'h0001_0000);
    irq_in[9] = 1'b0;
    expect_irq("R4 falling edge latched", 32'h0000_0609);
    wr(8'h60, 32'h0000_0109);
    expect_irq("R5 falling latch cleared", 32'h0001_0000);
    irq_in[9] = 1'b1;
    settle();
    wr(8'h08, 32'h0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_disable();
    wr(8'h18, 32'h0);
    wr(8'h04, 32'h0000_0400);
    expect_irq("R6 level 0 blocks pending src5", 32'h0001_0000);
    expect_reg("R6 src5 still pending", 8'h80, 32'h0000_0020);
    wr(8'h18, 32'h0000_0300);
    expect_irq("R6 src5 enabled at level 3", 32'h0000_0305);
  endtask

  task automatic t_priority();
    wr(8'h08, 32'h0000_0100);
    wr(8'h28, 32'h0000_0007);
    expect_irq("R7 higher level src12 wins", 32'h0000_070C);
    wr(8'h28, 32'h0000_0003);
    expect_irq("R7 tie goes to src5", 32'h0000_0305);
    wr(8'h10, 32'h0000_0300);
    wr(8'h04, 32'h0000_0404);
    expect_irq("R7 tie goes to src1", 32'h0000_0301);
  endtask

  task automatic t_mask();
    wr(8'h40, 32'h2);
    expect_irq("R8 level 3 above threshold 2", 32'h0000_0301);
    wr(8'h40, 32'h3);
    expect_irq("R8 level 3 equal to threshold 3", 32'h0001_0000);
    wr(8'h28, 32'h0000_0004);
    expect_irq("R8 level 4 above threshold 3", 32'h0000_040C);
    wr(8'h40, 32'h7);
    expect_irq("R8 threshold 7 blocks all", 32'h0001_0000);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_enable();
    wr(8'h00, 32'h0);
    expect_irq("R9 global disable", 32'h0001_0000);
    wr(8'h00, 32'h1);
    expect_irq("R9 global enable restored", 32'h0000_040C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_regmap();
    t_level_modes();
    t_edge();
    t_clear();
    t_disable();
    t_priority();
    t_mask();
    t_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule